// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is a watchdog for a small controller core. A tick, taken either from a free-running watchdog oscillator or from the instruction clock, passes through a power-of-two prescaler and then into an 8-bit main counter. When the main counter wraps, the block raises a reset request. If the core is running normally, the request is a full chip reset. If the core is halted, the request is a warm reset that touches only the program counter and the stack pointer.

Software restarts the count in one of two ways, chosen by an option bit. In single mode, one clear strobe is enough. In dual mode, two separate part strobes must both arrive, in either order. External reset and halt entry also restart the count.

A 10-bit status word holds the prescaler select, five user flags, and two read-only cause flags. The timeout flag (TO) records that an overflow happened. The powered-down flag (PDF) records that a halt was entered. Firmware reads these two flags after a reset to find out why it is running.

Top module: `wdog_core`

## Requirements
- R1: After power-up reset (`rst`), `status` equals 10'h007, and both request outputs are low.
- R2: The overflow period is 256 × 2^sel counted ticks after a clear, where sel is `status[2:0]` (000 gives 1:1, 111 gives 1:128). The first counted tick is the one in the cycle after the clear.
- R3: When `dual_clear`=0, a `clr_single` pulse restarts both the prescaler and the main counter.
- R4: When `dual_clear`=1, the count restarts only after both `clr_part1` and `clr_part2` have been seen, in either order, and then both seen-marks are dropped. In this mode `clr_single` does not restart the count. When `dual_clear`=0, the part strobes have no effect.
- R5: `ext_rst` and `halt_enter` also restart the count. Any restart in the cycle of a wrap wins, and that wrap raises no request.
- R6: A wrap while `halted`=0 gives a one-cycle `chip_rst_req` pulse in the cycle after the wrap edge, and sets TO (`status[8]`).
- R7: A wrap while `halted`=1 gives only a one-cycle `warm_rst_req` pulse, and it also sets TO. The two requests are never high together.
- R8: `halt_enter` sets PDF (`status[9]`) and clears TO. `clr_single` clears PDF in either clear mode. `ext_rst` keeps both flags. `rst` clears both flags.
- R9: When `tick_src`=1, the count uses `instr_tick` and does not advance while `halted`=1. When `tick_src`=0, the count uses `osc_tick`.
- R10: `stat_we` writes `stat_wdata[2:0]` into the select field and `stat_wdata[7:3]` into the user flags (`status[7:3]`). The user flags can be read back and have no effect on timing. `ext_rst` does not change `status[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| ext_rst | input | 1 | External reset; restarts the count |
| tick_src | input | 1 | 0 = watchdog oscillator tick, 1 = instruction tick |
| osc_tick | input | 1 | Watchdog oscillator tick enable |
| instr_tick | input | 1 | Instruction clock tick enable |
| halted | input | 1 | Core is in the halt state |
| halt_enter | input | 1 | Halt instruction strobe |
| dual_clear | input | 1 | Clear discipline: 0 single, 1 two-part |
| clr_single | input | 1 | Single clear instruction strobe |
| clr_part1 | input | 1 | First part clear strobe |
| clr_part2 | input | 1 | Second part clear strobe |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 8 | Status write data (select and user flags) |
| chip_rst_req | output | 1 | Full chip reset request pulse |
| warm_rst_req | output | 1 | PC/SP-only reset request pulse |
| status | output | 10 | {PDF, TO, user[7:3], select[2:0]} |

## Verification
A wrong prescaler tap or a miscount in the main counter shows up at the ports as a request pulse that arrives in the wrong cycle. This error is visible at the first wrap after a clear, so the bench predicts the exact request cycle for each scenario and compares pulse kind and timing.

A stuck or leaking seen-mark in two-part mode changes the time of the next request by hundreds of cycles, which makes it easy to detect.

A flag fault shows in `status` on the cycle after the halt, the clear or the overflow that should have changed it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W = 3;
    localparam int PRE_W = (1 << SEL_W) - 1;
    localparam int CNT_W = 8;

    typedef enum logic {
        SRC_OSC   = 1'b0,
        SRC_INSTR = 1'b1
    } tick_src_e;

    // Status word layout, MSB first
    typedef struct packed {
        logic             pdf;
        logic             to;
        logic [3:0]       user_hi;
        logic             user_lo;
        logic [SEL_W-1:0] sel;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef struct packed {
        logic single;
        logic part1;
        logic part2;
    } clr_cmd_t;

    // Mask of the low 'sel' prescaler bits
    function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/wdog_clear_ctrl.sv
module wdog_clear_ctrl
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_rst,
    input  logic     halt_enter,
    input  logic     dual_mode,
    input  clr_cmd_t cmd,
    output logic     clr_all
);

    logic seen1_q, seen2_q;
    logic pair_done;
    logic sw_clr;

    assign pair_done = dual_mode && (seen1_q || cmd.part1) && (seen2_q || cmd.part2);
    assign sw_clr    = dual_mode ? pair_done : cmd.single;
    assign clr_all   = ext_rst || halt_enter || sw_clr;

    always_ff @(posedge clk) begin
        if (rst || ext_rst || halt_enter || pair_done || !dual_mode) begin
            seen1_q <= 1'b0;
            seen2_q <= 1'b0;
        end else begin
            if (cmd.part1) seen1_q <= 1'b1;
            if (cmd.part2) seen2_q <= 1'b1;
        end
    end

    AST_SEEN_DROPPED: assert property (@(posedge clk) disable iff (rst)
        pair_done |=> (!seen1_q && !seen2_q)); // R4

    AST_SINGLE_MODE_NO_MARKS: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |=> (!seen1_q && !seen2_q)); // R4

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);

    logic [PRE_W-1:0] pre_q;
    logic [CW-1:0]    cnt_q;
    logic [PRE_W-1:0] mask;
    logic             div_tick;

    assign mask     = div_mask(sel);
    assign div_tick = tick && ((pre_q & mask) == mask);
    assign ovf      = div_tick && (cnt_q == {CW{1'b1}}) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + 1'b1;
            if (div_tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_BACK_TO_BACK_WRAP: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf); // R2

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> ($stable(cnt_q) && $stable(pre_q))); // R9

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && pre_q == '0)); // R5

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       halt_enter,
    input  logic       clr_single,
    input  logic       ovf,
    output stat_t      stat
);

    stat_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.sel     <= '1;
        end else begin
            if (we) begin
                st_q.sel     <= wdata[SEL_W-1:0];
                st_q.user_lo <= wdata[3];
                st_q.user_hi <= wdata[7:4];
            end
            if (halt_enter) begin
                st_q.pdf <= 1'b1;
                st_q.to  <= 1'b0;
            end else begin
                if (ovf)        st_q.to  <= 1'b1;
                if (clr_single) st_q.pdf <= 1'b0;
            end
        end
    end

    assign stat = st_q;

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        halt_enter |=> (stat.pdf && !stat.to)); // R8

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.to && !halt_enter) |=> stat.to); // R6

    AST_PDF_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_single && !halt_enter) |=> !stat.pdf); // R8

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst,
    input  logic              tick_src,
    input  logic              osc_tick,
    input  logic              instr_tick,
    input  logic              halted,
    input  logic              halt_enter,
    input  logic              dual_clear,
    input  logic              clr_single,
    input  logic              clr_part1,
    input  logic              clr_part2,
    input  logic              stat_we,
    input  logic [7:0]        stat_wdata,
    output logic              chip_rst_req,
    output logic              warm_rst_req,
    output logic [STAT_W-1:0] status
);

    clr_cmd_t  cmd;
    tick_src_e src;
    logic      clr_all;
    logic      tick;
    logic      ovf;
    stat_t     stat;
    logic      chip_q, warm_q;

    assign cmd  = '{single: clr_single, part1: clr_part1, part2: clr_part2};
    assign src  = tick_src_e'(tick_src);
    assign tick = (src == SRC_INSTR) ? (instr_tick && !halted) : osc_tick;

    wdog_clear_ctrl u_clear (
        .clk        (clk),
        .rst        (rst),
        .ext_rst    (ext_rst),
        .halt_enter (halt_enter),
        .dual_mode  (dual_clear),
        .cmd        (cmd),
        .clr_all    (clr_all)
    );

    wdog_counter #(.CW(CW)) u_count (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_all),
        .tick (tick),
        .sel  (stat.sel),
        .ovf  (ovf)
    );

    wdog_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .we         (stat_we),
        .wdata      (stat_wdata),
        .halt_enter (halt_enter),
        .clr_single (clr_single),
        .ovf        (ovf),
        .stat       (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_q <= 1'b0;
            warm_q <= 1'b0;
        end else begin
            chip_q <= ovf && !halted;
            warm_q <= ovf && halted;
        end
    end

    assign chip_rst_req = chip_q;
    assign warm_rst_req = warm_q;
    assign status       = stat;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req)); // R7

    AST_CHIP_PULSE: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req); // R6

    AST_TO_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_req || warm_rst_req) |-> status[8]); // R6

    AST_INSTR_HALT_STALL: assert property (@(posedge clk) disable iff (rst)
        (tick_src && halted) |=> !(chip_rst_req || warm_rst_req)); // R9

endmodule

// File: tb/wdog_core_bench.sv
module wdog_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst, ext_rst, tick_src, osc_tick, instr_tick, halted, halt_enter;
    logic       dual_clear, clr_single, clr_part1, clr_part2, stat_we;
    logic [7:0] stat_wdata;
    logic       chip_rst_req, warm_rst_req;
    logic [9:0] status;

    typedef struct {
        int cyc;
        bit warm;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_core u_wdog_core (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .tick_src(tick_src),
        .osc_tick(osc_tick), .instr_tick(instr_tick), .halted(halted),
        .halt_enter(halt_enter), .dual_clear(dual_clear), .clr_single(clr_single),
        .clr_part1(clr_part1), .clr_part2(clr_part2), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .chip_rst_req(chip_rst_req),
        .warm_rst_req(warm_rst_req), .status(status)
    );

    task automatic chk(input string req, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, expv);
        end
    endtask

    task automatic push(input int at, input bit warm, input string req);
        exp_t e;
        e.cyc  = at;
        e.warm = warm;
        exp_q.push_back(e);
        $display("expect %s request at cycle %0d (%s)", warm ? "warm" : "chip", at, req);
    endtask

    // Monitor: every request pulse must match the head of the queue
    always @(negedge clk) begin
        if (!rst && !done && (chip_rst_req || warm_rst_req)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected request at cycle %0d actual chip=%0b warm=%0b expected none",
                         cyc, chip_rst_req, warm_rst_req);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.cyc != cyc || e.warm != warm_rst_req || e.warm == chip_rst_req) begin
                    errors++;
                    $display("FAIL R6/R7 request actual cycle=%0d warm=%0b chip=%0b expected cycle=%0d warm=%0b",
                             cyc, warm_rst_req, chip_rst_req, e.cyc, e.warm);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic seg_done(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing request actual pending=%0d expected 0 (head cycle %0d)",
                     req, exp_q.size(), exp_q[0].cyc);
            exp_q.delete();
        end
    endtask

    task automatic write_stat(input logic [7:0] d);
        stat_we = 1'b1; stat_wdata = d; step(); stat_we = 1'b0;
    endtask

    task automatic pulse_single();   clr_single = 1'b1; step(); clr_single = 1'b0; endtask
    task automatic pulse_part1();    clr_part1  = 1'b1; step(); clr_part1  = 1'b0; endtask
    task automatic pulse_part2();    clr_part2  = 1'b1; step(); clr_part2  = 1'b0; endtask
    task automatic pulse_ext();      ext_rst    = 1'b1; step(); ext_rst    = 1'b0; endtask

    initial begin
        int n, m;
        rst = 1'b1; ext_rst = 1'b0; tick_src = 1'b0; osc_tick = 1'b1; instr_tick = 1'b0;
        halted = 1'b0; halt_enter = 1'b0; dual_clear = 1'b0; clr_single = 1'b0;
        clr_part1 = 1'b0; clr_part2 = 1'b0; stat_we = 1'b0; stat_wdata = '0;
        step(); step(); step();
        chk("R1 status after power-up", status, 10'h007);
        chk("R1 chip request idle", chip_rst_req, 0);
        chk("R1 warm request idle", warm_rst_req, 0);
        rst = 1'b0;
        step();

        // R10 user flags writable, select 1:1; R3 single clear; R6 chip request
        write_stat(8'hF8);
        chk("R10 status write readback", status[7:0], 8'hF8);
        n = cyc; pulse_single(); push(n + 257, 1'b0, "R2 R3 sel0");
        wait_until(n + 260);
        seg_done("R3");
        chk("R6 TO set after overflow", status[8], 1);
        chk("R10 user flags kept", status[7:0], 8'hF8);

        // R2 ratio 1:4
        write_stat(8'h02);
        n = cyc; pulse_single(); push(n + 1 + 1024, 1'b0, "R2 sel2");
        wait_until(n + 1028);
        seg_done("R2");

        // R9 instruction tick stalls while halted
        write_stat(8'h00);
        n = cyc;
        halted = 1'b1; tick_src = 1'b1; instr_tick = 1'b1; osc_tick = 1'b0;
        pulse_single();
        wait_until(n + 600);
        seg_done("R9 stall");
        m = cyc; halted = 1'b0; push(m + 256, 1'b0, "R9 resume");
        wait_until(m + 258);
        seg_done("R9");
        tick_src = 1'b0; osc_tick = 1'b1; instr_tick = 1'b0;

        // R5 halt entry restarts; R7 warm request; R8 flags
        n = cyc; halted = 1'b1; halt_enter = 1'b1; step(); halt_enter = 1'b0;
        push(n + 257, 1'b1, "R7 halted wrap");
        chk("R8 PDF/TO after halt entry", status[9:8], 2'b10);
        wait_until(n + 259);
        seg_done("R7");
        chk("R7 TO set by halted wrap", status[8], 1);
        halted = 1'b0;

        // R4 dual mode, part2 then part1; single ignored; R8 flags across ext reset
        dual_clear = 1'b1;
        n = cyc; pulse_ext();
        chk("R8 flags kept by ext reset", status[9:8], 2'b11);
        chk("R10 ext reset keeps low byte", status[7:0], 8'h00);
        wait_until(n + 50); pulse_part2();
        wait_until(n + 80); pulse_single();
        step();
        chk("R8 PDF cleared by single clear", status[9], 0);
        wait_until(n + 150); pulse_part1();
        push(n + 151 + 256, 1'b0, "R4 pair complete");
        wait_until(n + 409);
        seg_done("R4 dual");

        // R4 repeated part1 only: no restart
        n = cyc; pulse_ext();
        push(n + 257, 1'b0, "R4 part1 only");
        wait_until(n + 10); pulse_part1();
        wait_until(n + 20); pulse_part1();
        wait_until(n + 259);
        seg_done("R4 half pair");

        // R4 part strobes ignored in single mode
        dual_clear = 1'b0;
        n = cyc; pulse_ext();
        push(n + 257, 1'b0, "R4 single mode parts");
        wait_until(n + 10); pulse_part1();
        wait_until(n + 20); pulse_part2();
        wait_until(n + 259);
        seg_done("R4 single");

        // R5 clear in the wrap cycle wins
        n = cyc; pulse_ext();
        wait_until(n + 256); pulse_single();
        push(n + 513, 1'b0, "R5 clear beats wrap");
        wait_until(n + 515);
        seg_done("R5");
        pulse_ext();

        step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= WATCHDOG);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual cycle=%0d expected finish earlier", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule